// File: doc/BRIEF.md
# Split-Chain Partial Scan Core

This block is a small three-register sequential circuit with scan test built in. Each register can be a scan cell: a 2:1 multiplexer in front of a D flip-flop. In normal mode the multiplexer passes the next-state logic. In scan mode it passes the chain's shift path instead. The registers are split into two parallel chains of unequal length, and each chain has its own serial input and serial output. Both chains shift together, so a full load takes as many clocks as the longer chain.

A mask parameter chooses which registers receive a scan multiplexer. This gives partial scan: registers whose next state depends on their own value get scan, and the others stay plain flip-flops. The chain routing skips any register without scan.

A test runs in three steps. First the chains load a state in scan mode. Then one clock in normal mode captures the response of the next-state logic. Finally more clocks in scan mode shift the captured values out at the serial outputs.

Top module: `split_scan_core`

## Requirements
- R1: A low `rst_n` at a rising clock edge clears all three registers to 0, whatever the mode and data inputs. After reset `scan_out` is 2'b00 and `po` is 0.
- R2: With `scan_mode`=0, at each clock every register loads its next state:
  - q0 <= pi[0]
  - q1 <= q1 ^ (pi[1] & q0)
  - q2 <= q2 ^ (pi[2] & q1)
- R3: The primary output is combinational: `po` = q0 ^ (q1 & q2).
- R4: With `scan_mode`=1, each scanned register loads the Q of the previous scanned register in its own chain. The first scanned register of a chain loads that chain's `scan_in` bit.
- R5: Chain 0 holds registers 0 to SPLIT-1 in that shift order and uses `scan_in[0]`/`scan_out[0]`. Chain 1 holds registers SPLIT to 2 and uses `scan_in[1]`/`scan_out[1]`. Both chains shift on the same clocks. With SPLIT=2, a full load of all three registers takes two clocks.
- R6: `scan_out[c]` is the Q of the last scanned register of chain c.
- R7: A register whose bit in SCAN_MASK is 0 always loads its R2 next state, including while `scan_mode`=1. It is also left out of its chain's shift path. With mask 3'b110, `scan_in[0]` goes directly into register 1.
- R8: A value captured with `scan_mode`=0 in a register that sits k scanned positions before its chain's output appears at `scan_out` after exactly k shift clocks. For example, register 0 of chain 0 appears after one shift clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all registers |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_mode | input | 1 | 1 selects shift, 0 selects functional capture |
| pi | input | 3 | Primary data inputs |
| scan_in | input | 2 | Serial input of chain 0 (bit 0) and chain 1 (bit 1) |
| scan_out | output | 2 | Serial output of chain 0 (bit 0) and chain 1 (bit 1) |
| po | output | 1 | Primary output |

## Verification
The registers can be seen only through `po` and the serial outputs. A wrong state bit in the last cell of a chain shows at `scan_out` on the next cycle. A wrong bit deeper in a chain shows only after enough shift clocks to move it to the end, or through `po` once the other two bits allow it through. Routing faults need separate checks: a wrong link in the chain, a wrong chain split, or a plain register that wrongly follows `scan_mode`. They show one or two clocks after a load, when the value that arrives at `scan_out` or `po` differs from what the shifted pattern predicts. The bench follows a reference model cycle by cycle for a full-scan instance and a partial-scan instance side by side, so such faults show on the first cycle they reach a port.

// File: rtl/split_scan_pkg.sv
package split_scan_pkg;
   localparam int NFF = 3;
   localparam int NCH = 2;
   typedef logic [NFF-1:0] ff_vec_t;

   // nearest scanned register below idx inside [lo, idx-1]; -1 if none
   function automatic int prev_scanned(input logic [NFF-1:0] mask, input int idx, input int lo);
      int r;
      r = -1;
      for (int j = lo; j < idx; j++)
         if (mask[j]) r = j;
      return r;
   endfunction

   // highest scanned register inside [lo, hi]; -1 if none
   function automatic int last_scanned(input logic [NFF-1:0] mask, input int lo, input int hi);
      int r;
      r = -1;
      for (int j = lo; j <= hi; j++)
         if (mask[j]) r = j;
      return r;
   endfunction
endpackage

// File: rtl/split_scan_logic.sv
module split_scan_logic
   import split_scan_pkg::*;
(
   input  ff_vec_t    q,
   input  logic [2:0] pi,
   output ff_vec_t    d_func,
   output logic       po
);
   always_comb begin
      d_func[0] = pi[0];
      d_func[1] = q[1] ^ (pi[1] & q[0]);
      d_func[2] = q[2] ^ (pi[2] & q[1]);
      po        = q[0] ^ (q[1] & q[2]);
   end
endmodule

// File: rtl/split_scan_cell.sv
module split_scan_cell #(
   parameter bit HAS_SCAN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode,
   input  logic func_d,
   input  logic shift_in,
   output logic q
);
   generate
      if (HAS_SCAN) begin : g_scan
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= mode ? shift_in : func_d;
         end

         // R4
         shift_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mode |=> (q == $past(shift_in)));
         // R2
         capture_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !mode |=> (q == $past(func_d)));
      end else begin : g_plain
         logic unused_pins;
         assign unused_pins = mode ^ shift_in;

         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= func_d;
         end

         // R7
         plain_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (q == $past(func_d)));
      end
   endgenerate
endmodule

// File: rtl/split_scan_core.sv
module split_scan_core
   import split_scan_pkg::*;
#(
   parameter logic [2:0] SCAN_MASK = 3'b111,
   parameter int         SPLIT     = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scan_mode,
   input  logic [2:0] pi,
   input  logic [1:0] scan_in,
   output logic [1:0] scan_out,
   output logic       po
);
   ff_vec_t q;
   ff_vec_t d_func;
   ff_vec_t shift_src;

   initial begin
      if (SPLIT < 1 || SPLIT > NFF-1)
         $error("SPLIT must leave at least one register in each chain");
   end

   split_scan_logic u_logic (
      .q      (q),
      .pi     (pi),
      .d_func (d_func),
      .po     (po)
   );

   generate
      for (genvar i = 0; i < NFF; i++) begin : g_ff
         localparam int CH  = (i < SPLIT) ? 0 : 1;
         localparam int LO  = (i < SPLIT) ? 0 : SPLIT;
         localparam int PRV = prev_scanned(SCAN_MASK, i, LO);

         if (PRV < 0) begin : g_head
            assign shift_src[i] = scan_in[CH];
         end else begin : g_link
            assign shift_src[i] = q[PRV];
         end

         split_scan_cell #(.HAS_SCAN(SCAN_MASK[i])) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (scan_mode),
            .func_d   (d_func[i]),
            .shift_in (shift_src[i]),
            .q        (q[i])
         );
      end

      for (genvar c = 0; c < NCH; c++) begin : g_chain
         localparam int LO   = (c == 0) ? 0 : SPLIT;
         localparam int HI   = (c == 0) ? SPLIT-1 : NFF-1;
         localparam int LAST = last_scanned(SCAN_MASK, LO, HI);

         if (LAST < 0) begin : g_empty
            initial $error("chain %0d has no scanned register", c);
            assign scan_out[c] = scan_in[c];
         end else begin : g_tail
            // R6
            assign scan_out[c] = q[LAST];
         end
      end
   endgenerate

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (q == '0));
endmodule

// File: tb/split_scan_core_test.sv
module split_scan_core_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       scan_mode;
   logic [2:0] pi;
   logic [1:0] scan_in;
   logic [1:0] so_full, so_part;
   logic       po_full, po_part;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [2:0] mf, mp;   // expected register contents

   always #(CLK_PERIOD/2) clk = ~clk;

   split_scan_core uut (
      .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .pi(pi),
      .scan_in(scan_in), .scan_out(so_full), .po(po_full)
   );

   split_scan_core #(.SCAN_MASK(3'b110), .SPLIT(2)) uut_part (
      .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .pi(pi),
      .scan_in(scan_in), .scan_out(so_part), .po(po_part)
   );

   function automatic logic [2:0] model_next(input logic [2:0] q, input logic [2:0] mask,
                                            input logic md, input logic [2:0] p,
                                            input logic [1:0] si);
      logic [2:0] f, s, n;
      f[0] = p[0];
      f[1] = q[1] ^ (p[1] & q[0]);
      f[2] = q[2] ^ (p[2] & q[1]);
      s[0] = si[0];
      s[1] = mask[0] ? q[0] : si[0];
      s[2] = si[1];
      for (int i = 0; i < 3; i++) n[i] = (md && mask[i]) ? s[i] : f[i];
      return n;
   endfunction

   task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic check_ports(input string tag);
      check({tag, " full scan_out"}, {1'b0, so_full}, {1'b0, mf[2], mf[1]});
      check({tag, " full po"}, {2'b0, po_full}, {2'b0, mf[0] ^ (mf[1] & mf[2])});
      check({tag, " part scan_out"}, {1'b0, so_part}, {1'b0, mp[2], mp[1]});
      check({tag, " part po"}, {2'b0, po_part}, {2'b0, mp[0] ^ (mp[1] & mp[2])});
   endtask

   task automatic cycle(input logic md, input logic [2:0] p, input logic [1:0] si);
      logic [2:0] nf, np;
      scan_mode = md; pi = p; scan_in = si;
      nf = model_next(mf, 3'b111, md, p, si);
      np = model_next(mp, 3'b110, md, p, si);
      @(posedge clk);
      @(negedge clk);
      mf = nf; mp = np;
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst_n = 1'b0; scan_mode = 1'b1; pi = 3'b111; scan_in = 2'b11;
      repeat (2) @(negedge clk);
      mf = 3'b000; mp = 3'b000;
      check("R1 full scan_out", {1'b0, so_full}, 3'b000);
      check("R1 full po", {2'b0, po_full}, 3'b000);
      check("R1 part scan_out", {1'b0, so_part}, 3'b000);
      rst_n = 1'b1;
   endtask

   task automatic t_load;
      // chain0 gets 1 then 0, chain1 gets 1 then 1: F0=0 F1=1 F2=1 after two clocks
      cycle(1'b1, 3'b000, 2'b11);
      check_ports("R4 first shift");
      cycle(1'b1, 3'b000, 2'b10);
      check("R5 two-clock load scan_out", {1'b0, so_full}, 3'b011);
      check("R3 po after load", {2'b0, po_full}, 3'b001);
      check_ports("R6 after load");
   endtask

   task automatic t_capture_unload;
      // from F0=0 F1=1 F2=1: capture gives F0=1 F1=1 F2=1
      cycle(1'b0, 3'b011, 2'b00);
      check("R2 capture scan_out", {1'b0, so_full}, 3'b011);
      check("R3 po after capture", {2'b0, po_full}, 3'b000);
      check_ports("R2 capture");
      cycle(1'b1, 3'b000, 2'b00);
      check("R8 F0 value after one shift", {2'b0, so_full[0]}, 3'b001);
      check_ports("R8 unload");
   endtask

   task automatic t_partial;
      // register 0 of the partial instance keeps following pi[0] in scan mode
      cycle(1'b1, 3'b001, 2'b01);
      check("R7 partial direct load of reg1", {2'b0, so_part[0]}, 3'b001);
      check_ports("R7 plain reg in scan mode");
      cycle(1'b1, 3'b000, 2'b00);
      check_ports("R7 plain reg follows pi");
      cycle(1'b1, 3'b001, 2'b00);
      check_ports("R7 plain reg follows pi again");
   endtask

   task automatic t_mixed;
      logic [7:0] lf = 8'hA5;
      for (int k = 0; k < 40; k++) begin
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         cycle(lf[0] & lf[3], lf[3:1], lf[5:4]);
         check_ports(lf[0] & lf[3] ? "R4 mixed shift" : "R2 mixed capture");
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; scan_mode = 1'b0; pi = '0; scan_in = '0;
      mf = '0; mp = '0;
      t_reset();
      t_load();
      t_capture_unload();
      t_partial();
      t_mixed();
      t_reset();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule